// File: doc/BRIEF.md
# Mode-Aware GPIO Port Register Block

This block holds the control state for one 8-bit general-purpose I/O port. A CPU reaches two registers through a simple register bus: a direction register and an output data register. The direction register selects, bit by bit, whether a pin is driven or only sampled. The data register holds the levels that driven pins present. The block sends an output enable and an output value for each pin to the pad buffers. It samples the pad inputs through a two-flop synchronizer.

A mode input moves the port into extended-bus operation. In that mode the pins belong to an external bidirectional data bus, so the port drives no output enables. Read-back of the data register follows a per-bit rule that depends on the mode.

There are two reset inputs. The system reset clears both registers. The watchdog-generated internal reset leaves both registers as they are. That reset input exists so that retention across a watchdog event can be observed.

Top module: `gpio_port8`

## Requirements
- R1: While `sys_rst` is high at a rising clock edge, both registers are cleared to 0x00. After that edge `pad_oe` and `pad_out` are 0x00.
- R2: A write with `bus_wr`=1 to address 0 loads the direction register on that clock edge. In normal mode `pad_oe` then equals the written value, where bit value 1 means the pin is an output.
- R3: A read with `bus_rd`=1 at address 0 returns 0xFF, because the direction register cannot be read back.
- R4: A write with `bus_wr`=1 to address 1 loads the data register on that clock edge. `pad_out` equals the data register in both modes.
- R5: In normal mode, a read at address 1 returns the stored data bit where the direction bit is 1. Where the direction bit is 0, it returns the pad level sampled two rising edges earlier.
- R6: In extended-bus mode (`ext_bus_mode`=1), `pad_oe` is 0x00 whatever the direction register holds.
- R7: In extended-bus mode, a read at address 1 returns the stored data bit where the direction bit is 1, and 1 where the direction bit is 0.
- R8: A pulse on `wdt_rst` changes neither the data register nor the direction register.
- R9: While `bus_rd` is 0, `bus_rdata` is 0x00.
- R10: When `sys_rst` and a register write fall on the same edge, the reset wins and the registers read as cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| sys_rst | input | 1 | Synchronous active-high system reset |
| wdt_rst | input | 1 | Watchdog internal reset pulse; registers are kept |
| ext_bus_mode | input | 1 | 1 = pins belong to the external data bus, 0 = normal I/O |
| bus_addr | input | 1 | Register select: 0 direction, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable to the pad buffers |
| pad_out | output | 8 | Per-pin output value to the pad buffers |

## Verification
Mixed direction patterns such as 0xF0, 0x0F, all-in and all-out are combined with pad values that differ from the stored data. Each read-back bit can then be traced to only one of three sources: stored data, pad level, or constant 1. The pad value is changed while a read is held, which exposes the two-clock synchronizer lag. The same patterns are repeated in extended-bus mode, where the direction-0 bits must read 1 and the output enables must stay off. A watchdog pulse between two known register states, and a write on the same edge as a system reset, complete the stimulus.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 1;

    localparam logic [ADDR_W-1:0] ADDR_DIR  = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 1'b1;

    typedef enum logic {
        MODE_GPIO   = 1'b0,
        MODE_EXTBUS = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
    } port_regs_t;

    // One read-back bit: driven pins show stored data; sampled pins show
    // the synchronized pad in normal mode and a constant 1 on the bus mode.
    function automatic logic readback_bit(
        input logic       dir_b,
        input logic       data_b,
        input logic       pin_b,
        input port_mode_e mode
    );
        if (dir_b)
            return data_b;
        else if (mode == MODE_EXTBUS)
            return 1'b1;
        else
            return pin_b;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              wdt_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output port_regs_t        regs_q
);

    logic wr_dir;
    logic wr_data;

    assign wr_dir  = wr_en && (addr == ADDR_DIR);
    assign wr_data = wr_en && (addr == ADDR_DATA);

    // Only the system reset clears state; the watchdog reset is not wired in.
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            regs_q <= '0;
        end else begin
            if (wr_dir)  regs_q.dir  <= wdata;
            if (wr_data) regs_q.data <= wdata;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        sys_rst |=> (regs_q.dir == '0 && regs_q.data == '0)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_en && addr == ADDR_DIR) |=> regs_q.dir == $past(wdata)); // R2

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_en && addr == ADDR_DATA) |=> regs_q.data == $past(wdata)); // R4

    AST_WDT_KEEPS: assert property (@(posedge clk) disable iff (sys_rst)
        (wdt_rst && !wr_en) |=> $stable(regs_q)); // R8

endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
module gpio_read_mux
    import gpio_port_pkg::*;
(
    input  port_regs_t        regs,
    input  logic [PORT_W-1:0] pin_sync,
    input  port_mode_e        mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [PORT_W-1:0] rdata
);

    logic [PORT_W-1:0] data_view;

    generate
        for (genvar b = 0; b < PORT_W; b++) begin : g_bit
            assign data_view[b] = readback_bit(regs.dir[b], regs.data[b],
                                               pin_sync[b], mode);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_DIR) rdata = '1;
            else                  rdata = data_view;
        end
    end

endmodule

// File: rtl/gpio_port8.sv
`timescale 1ns/1ps
module gpio_port8
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              wdt_rst,
    input  logic              ext_bus_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);

    localparam int SYNC_STAGES = 2;

    port_regs_t        regs;
    logic [PORT_W-1:0] pin_sync;
    port_mode_e        mode;

    assign mode = port_mode_e'(ext_bus_mode);

    gpio_pin_sync #(
        .WIDTH  (PORT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (sys_rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs u_regs (
        .clk     (clk),
        .sys_rst (sys_rst),
        .wdt_rst (wdt_rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .regs_q  (regs)
    );

    gpio_read_mux u_rmux (
        .regs     (regs),
        .pin_sync (pin_sync),
        .mode     (mode),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .rdata    (bus_rdata)
    );

    // Pad drive: on the external bus the port releases every enable.
    always_comb begin
        pad_out = regs.data;
        pad_oe  = (mode == MODE_EXTBUS) ? '0 : regs.dir;
    end

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (sys_rst)
        (bus_rd && bus_addr == ADDR_DIR) |-> bus_rdata == '1); // R3

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (sys_rst)
        !bus_rd |-> bus_rdata == '0); // R9

    AST_EXT_NO_OE: assert property (@(posedge clk) disable iff (sys_rst)
        ext_bus_mode |-> pad_oe == '0); // R6

    AST_EXT_IN_ONES: assert property (@(posedge clk) disable iff (sys_rst)
        (ext_bus_mode && bus_rd && bus_addr == ADDR_DATA)
            |-> ((bus_rdata | pad_oe) == '1 || ~u_regs.regs_q.dir == (bus_rdata & ~u_regs.regs_q.dir))); // R7

endmodule

// File: tb/gpio_port8_test.sv
`timescale 1ns/1ps
module gpio_port8_test;

    logic       clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       wdt_rst = 1'b0;
    logic       ext_bus_mode = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit live  = 1'b0;

    always #2 clk = ~clk;

    gpio_port8 uut (
        .clk          (clk),
        .sys_rst      (sys_rst),
        .wdt_rst      (wdt_rst),
        .ext_bus_mode (ext_bus_mode),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out)
    );

    // Behavioural reference model
    logic [7:0] m_dir = 8'h00, m_data = 8'h00;
    logic [7:0] pad_hist [$];

    always @(posedge clk) begin
        if (sys_rst) begin
            m_dir  <= 8'h00;
            m_data <= 8'h00;
            pad_hist = {8'h00, 8'h00};
        end else begin
            if (bus_wr && bus_addr == 1'b0) m_dir  <= bus_wdata;
            if (bus_wr && bus_addr == 1'b1) m_data <= bus_wdata;
            pad_hist.push_back(pad_in);
            void'(pad_hist.pop_front());
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !sys_rst) begin
            logic [7:0] pin;
            logic [7:0] exp_rd;
            pin = pad_hist[0];
            check("R4 pad_out", pad_out, m_data);
            if (ext_bus_mode) check("R6 pad_oe", pad_oe, 8'h00);
            else              check("R2 pad_oe", pad_oe, m_dir);
            if (!bus_rd) begin
                check("R9 idle rdata", bus_rdata, 8'h00);
            end else if (bus_addr == 1'b0) begin
                check("R3 dir read", bus_rdata, 8'hFF);
            end else if (ext_bus_mode) begin
                exp_rd = (m_data & m_dir) | ~m_dir;
                check("R7 ext read", bus_rdata, exp_rd);
            end else begin
                exp_rd = (m_data & m_dir) | (pin & ~m_dir);
                check("R5 gpio read", bus_rdata, exp_rd);
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] keep_out, keep_oe;
        // R10: write collides with system reset
        tick();
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hFF;
        tick();
        bus_wr = 1'b0;
        sys_rst = 1'b0;
        @(negedge clk);
        check("R10 reset beats write", pad_out, 8'h00);
        check("R1 reset oe", pad_oe, 8'h00);
        check("R1 reset out", pad_out, 8'h00);
        live = 1'b1;
        tick();

        // Mixed direction, normal mode
        write_reg(1'b0, 8'hF0);
        write_reg(1'b1, 8'hA5);
        pad_in = 8'h3C;
        bus_rd = 1'b1; bus_addr = 1'b1;
        tick(3);
        pad_in = 8'hC3;           // lag visible over the next cycles
        tick(3);
        bus_addr = 1'b0;
        tick(2);
        bus_rd = 1'b0;
        tick();

        write_reg(1'b0, 8'h0F);
        pad_in = 8'h55;
        bus_rd = 1'b1; bus_addr = 1'b1;
        tick(4);
        write_reg(1'b0, 8'h00);
        tick(2);
        write_reg(1'b0, 8'hFF);
        write_reg(1'b1, 8'h5A);
        tick(2);
        bus_rd = 1'b0;

        // Extended-bus mode
        write_reg(1'b0, 8'hCC);
        write_reg(1'b1, 8'h0F);
        ext_bus_mode = 1'b1;
        pad_in = 8'h00;
        bus_rd = 1'b1; bus_addr = 1'b1;
        tick(3);
        write_reg(1'b0, 8'h00);
        tick(2);
        write_reg(1'b0, 8'h81);
        tick(2);
        bus_addr = 1'b0;
        tick();
        bus_rd = 1'b0;
        ext_bus_mode = 1'b0;
        tick();

        // Watchdog reset retention
        write_reg(1'b0, 8'h3C);
        write_reg(1'b1, 8'h96);
        @(negedge clk);
        keep_out = pad_out; keep_oe = pad_oe;
        tick();
        wdt_rst = 1'b1;
        tick(3);
        wdt_rst = 1'b0;
        @(negedge clk);
        check("R8 data kept", pad_out, keep_out);
        check("R8 dir kept", pad_oe, keep_oe);
        check("R8 data value", pad_out, 8'h96);
        tick(2);

        // System reset clears again
        sys_rst = 1'b1;
        tick();
        sys_rst = 1'b0;
        @(negedge clk);
        check("R1 reclear out", pad_out, 8'h00);
        check("R1 reclear oe", pad_oe, 8'h00);
        tick(3);

        done = 1'b1;
        summary();
    end

endmodule